// File: doc/BRIEF.md
# Mailbox Receive FIFO Port

This block is the receiving side of an inter-processor mailbox. Remote senders push 64-bit messages into a circular buffer. Each message carries the number of the channel that sent it. A local processor reads the oldest message through three 32-bit registers: its channel number, its lower word and its upper word. It then writes a trigger register to release that entry, and the next message moves to the head.

The block does not report how many messages it holds. Software works out the occupancy from the raw read and write positions in the status word. When the two positions are equal, a separate full bit decides whether the buffer is full or empty. The depth register reads back the depth minus one, so software can wrap its arithmetic without knowing the parameter.

A not-empty interrupt has its own mask bit and a sticky pending bit. The handler is expected to drain the buffer first and then clear the pending bit.

Top module: `mbox_rx_fifo`

## Requirements
- R1: After reset, both positions are 0, the full bit is 0, the mask register reads 0x1F, pending reads 0 and `irq` is low.
- R2: Each accepted push stores `push_data` and `push_id`. Entries leave in arrival order. At the head, offset 0x00 returns the channel ID in its low bits, offset 0x04 returns data bits 31:0 and offset 0x08 returns data bits 63:32.
- R3: Writing a value with bit 0 set to offset 0x0C removes the head entry. A write with bit 0 clear changes nothing. A write while the buffer is empty also changes nothing.
- R4: Offset 0x14 returns the read position in bits 31:24, the write position in bits 23:16 and the full flag in bit 2. Every other bit reads 0.
- R5: Both positions advance modulo DEPTH. The count of stored entries is (write − read) when write > read, and (DEPTH − read + write) when write < read.
- R6: A push while the buffer is full is dropped. The positions, the full flag and the stored entries stay unchanged. Equal positions with bit 2 set mean the buffer holds DEPTH entries.
- R7: Offset 0x24 returns DEPTH − 1.
- R8: Offset 0x1C is a 5-bit mask with a reset value of 0x1F. When the buffer is non-empty and mask bit 0 is 0, pending (bit 0 of offset 0x18) is set on the next clock edge. `irq` follows pending. While mask bit 0 is 1, pending is not set.
- R9: Writing a value with bit 0 set to offset 0x18 clears pending on that edge. Pending otherwise stays set, even after the buffer drains. If entries remain and the interrupt is unmasked, pending sets again one cycle after the clear.
- R10: Writing 0 to offset 0x10 empties the buffer: both positions go to 0 and the full flag goes to 0. This takes priority over a push or a pop on the same edge. A non-zero write to 0x10 is ignored.
- R11: While the buffer is empty, offsets 0x00, 0x04 and 0x08 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Remote sender offers a message this cycle |
| push_data | input | 64 | Message payload |
| push_id | input | ID_W | Source channel of the message |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Not-empty interrupt, equal to the pending bit |

## Verification
A corrupted read or write position shows up in the status word at the next read. It also changes which message appears at the head, so a pop sequence returns payloads out of order or repeated. A lost or stuck full flag is the subtle case: the positions look identical for a full and an empty buffer. The fault only becomes visible through bit 2, through head registers that read 0, or through a ninth push that is not dropped. A wrong pending update shows on `irq` within one cycle after a push, a clear or a mask change. The bench samples `irq` exactly one edge after each of these events.

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int ID_W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_valid,
  input  logic [63:0]     push_data,
  input  logic [ID_W-1:0] push_id,
  input  logic            reg_wr,
  input  logic [5:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = ID_W + 64;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  localparam logic [5:0] A_ID   = 6'h00;
  localparam logic [5:0] A_LO   = 6'h04;
  localparam logic [5:0] A_HI   = 6'h08;
  localparam logic [5:0] A_POP  = 6'h0C;
  localparam logic [5:0] A_RST  = 6'h10;
  localparam logic [5:0] A_STS  = 6'h14;
  localparam logic [5:0] A_PEND = 6'h18;
  localparam logic [5:0] A_MASK = 6'h1C;
  localparam logic [5:0] A_DEP  = 6'h24;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, pending;
  logic [4:0]    mask;

  wire empty   = (wp == rp) && !full;
  wire flush   = reg_wr && reg_addr == A_RST && reg_wdata == 32'd0;
  wire pop_req = reg_wr && reg_addr == A_POP && reg_wdata[0];
  wire clr     = reg_wr && reg_addr == A_PEND && reg_wdata[0];
  wire do_push = push_valid && !full && !flush;
  wire do_pop  = pop_req && !empty && !flush;
  wire [PW-1:0] wp_n = (wp == LAST) ? '0 : wp + 1'b1;
  wire [PW-1:0] rp_n = (rp == LAST) ? '0 : rp + 1'b1;
  wire [EW-1:0] head = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= {push_id, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      full <= 1'b0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
      full <= 1'b0;
    end else begin
      if (do_push) wp <= wp_n;
      if (do_pop) rp <= rp_n;
      if (do_push && !do_pop && wp_n == rp) full <= 1'b1;
      else if (do_pop && !do_push) full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= 5'h1F;
      pending <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_MASK) mask <= reg_wdata[4:0];
      if (clr) pending <= 1'b0;
      else if (!empty && !mask[0]) pending <= 1'b1;
    end
  end

  assign irq = pending;

  always_comb begin
    unique case (reg_addr)
      A_ID:    reg_rdata = 32'(head[EW-1:64]);
      A_LO:    reg_rdata = head[31:0];
      A_HI:    reg_rdata = head[63:32];
      A_STS:   reg_rdata = {8'(rp), 8'(wp), 13'd0, full, 2'b00};
      A_PEND:  reg_rdata = {31'd0, pending};
      A_MASK:  reg_rdata = {27'd0, mask};
      A_DEP:   reg_rdata = 32'(DEPTH - 1);
      default: reg_rdata = 32'd0;
    endcase
  end

  p_full_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (wp == rp));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && !pop_req && !flush) |=> (full && $stable(wp)));
  p_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_valid && !flush) |=> ($stable(rp) && $stable(wp)));
  p_pend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !mask[0] && !clr) |=> irq);
  p_pend_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq);
  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wp == '0 && rp == '0 && !full));
endmodule

// File: tb/test_mbox_rx_fifo.sv
module test_mbox_rx_fifo;
  localparam int DEPTH = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [63:0] push_data = '0;
  logic [7:0] push_id = '0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  mbox_rx_fifo #(.DEPTH(DEPTH), .ID_W(8)) i_mbox_rx_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_id(push_id), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] id, input logic [63:0] d);
    push_valid = 1'b1; push_id = id; push_data = d;
    @(posedge clk); @(negedge clk);
    push_valid = 1'b0;
  endtask

  function automatic logic [63:0] pat(input int k);
    return {32'hA000_0000 + 32'(k), 32'h0000_5000 + 32'(k * 3)};
  endfunction

  task automatic expect_head(input string req, input int k);
    logic [31:0] v;
    logic [63:0] p;
    p = pat(k);
    rd(6'h00, v); chk(req, v, 32'(k + 1));
    rd(6'h04, v); chk(req, v, p[31:0]);
    rd(6'h08, v); chk(req, v, p[63:32]);
  endtask

  function automatic logic [31:0] sts(input int r, input int w, input bit f);
    return {8'(r), 8'(w), 13'd0, f, 2'b00};
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(6'h14, v); chk("R1 status", v, 32'd0);
    rd(6'h1C, v); chk("R1 mask", v, 32'h1F);
    rd(6'h18, v); chk("R1 pending", v, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(6'h24, v); chk("R7 depth", v, 32'(DEPTH - 1));
    rd(6'h00, v); chk("R11 empty id", v, 32'd0);
    rd(6'h04, v); chk("R11 empty lo", v, 32'd0);
    rd(6'h08, v); chk("R11 empty hi", v, 32'd0);
  endtask

  task automatic t_order;
    logic [31:0] v;
    for (int k = 0; k < 3; k++) push(8'(k + 1), pat(k));
    rd(6'h14, v); chk("R4 status after 3 pushes", v, sts(0, 3, 0));
    expect_head("R2 head 0", 0);
    wr(6'h0C, 32'h0);
    expect_head("R3 pop with bit0 clear ignored", 0);
    wr(6'h0C, 32'h1);
    expect_head("R2 head 1", 1);
    wr(6'h0C, 32'h1);
    expect_head("R2 head 2", 2);
    wr(6'h0C, 32'h1);
    rd(6'h14, v); chk("R4 status drained", v, sts(3, 3, 0));
    wr(6'h0C, 32'h1);
    rd(6'h14, v); chk("R3 pop on empty ignored", v, sts(3, 3, 0));
  endtask

  task automatic t_fill_drop;
    logic [31:0] v;
    push(8'h1, pat(0));
    wr(6'h10, 32'h5);
    rd(6'h14, v); chk("R10 nonzero write ignored", v, sts(3, 4, 0));
    wr(6'h10, 32'h0);
    rd(6'h14, v); chk("R10 reset to empty", v, sts(0, 0, 0));
    for (int k = 0; k < DEPTH; k++) push(8'(k + 1), pat(k));
    rd(6'h14, v); chk("R6 full flag set", v, sts(0, 0, 1));
    push(8'h77, 64'hDEAD_BEEF_DEAD_BEEF);
    rd(6'h14, v); chk("R6 push into full dropped", v, sts(0, 0, 1));
    for (int k = 0; k < DEPTH; k++) begin
      expect_head("R6 contents kept", k);
      wr(6'h0C, 32'h1);
    end
    rd(6'h14, v); chk("R5 wrapped to empty", v, sts(0, 0, 0));
    rd(6'h00, v); chk("R11 empty after drain", v, 32'd0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    for (int k = 0; k < 5; k++) push(8'(k + 1), pat(k));
    for (int k = 0; k < 5; k++) wr(6'h0C, 32'h1);
    for (int k = 0; k < 5; k++) push(8'(k + 1), pat(k));
    rd(6'h14, v); chk("R5 write position wraps", v, sts(5, 2, 0));
    chk("R5 occupancy", 32'(DEPTH - int'(v[31:24]) + int'(v[23:16])), 32'd5);
    expect_head("R5 head after wrap", 0);
    wr(6'h10, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    push(8'h1, pat(0));
    @(posedge clk); @(negedge clk);
    chk("R8 masked no irq", {31'd0, irq}, 32'd0);
    wr(6'h1C, 32'h1E);
    chk("R8 mask written", {31'd0, irq}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R8 irq set", {31'd0, irq}, 32'd1);
    rd(6'h18, v); chk("R8 pending bit", v, 32'd1);
    wr(6'h18, 32'h1);
    chk("R9 cleared", {31'd0, irq}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R9 re-set while data remains", {31'd0, irq}, 32'd1);
    wr(6'h0C, 32'h1);
    @(posedge clk); @(negedge clk);
    chk("R9 sticky after drain", {31'd0, irq}, 32'd1);
    wr(6'h18, 32'h1);
    @(posedge clk); @(negedge clk);
    chk("R9 stays clear when empty", {31'd0, irq}, 32'd0);
    wr(6'h1C, 32'h1F);
    rd(6'h1C, v); chk("R8 mask readback", v, 32'h1F);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_order;
    t_fill_drop;
    t_wrap;
    t_irq;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule